// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing register front end of a peripheral controller. The host sees only two byte-wide locations. Location 0 is the address/status port and location 1 is the data port. Behind them sits a bank of 26 internal byte registers. The host writes a register number to location 0. It then reads or writes that register through location 1.

After each data-port access the block moves its register pointer on by one. Multi-byte fields can therefore be streamed with a single select. Examples are the 24-bit transfer count in registers 18 to 20 and a command descriptor of up to 12 bytes starting at register 3.

A read of location 0 returns a live auxiliary status byte. The block also signals three events to the bus engine beside it: a command has been written, the host has written the data register, and the host has read the data register. The bus engine itself is modelled by a few status inputs. These inputs report busy, a parity error, command completion, an interrupt with its completion code, a request for data, and a received byte.

Top module: `ind_reg_port`

## Requirements
- R1: A read at location 0 (`a0`=0) returns the auxiliary status byte on `rdata`, combinationally, in the same cycle. Its bits are: bit 7 interrupt pending, bit 6 last command ignored, bit 5 busy (live copy of `eng_busy`), bit 4 command in progress, bits 3 and 2 always 0, bit 1 parity error (live copy of `eng_perr`), bit 0 data buffer ready.
- R2: A write at location 0 loads the register pointer from `wdata`. A value of 26 or more is ignored and leaves the pointer where it was.
- R3: A data-port access (`a0`=1) reads or writes the register the pointer selects. After the access the pointer moves up by one while it is below 24. At 24 (command) or 25 (data) the pointer stays where it is.
- R4: Selecting register 18 once and making three data accesses moves the transfer count high, middle, low. Selecting register 3 once and writing 12 bytes fills registers 3 through 14 in order.
- R5: Writing register 24 while command-in-progress is clear stores the byte, sets command-in-progress, and pulses `cmd_stb` for one cycle in the next cycle. `cmd_byte` carries the byte: bit 7 is the single-byte-transfer qualifier and bits 6:0 are the operation code. A pulse on `eng_done` clears command-in-progress.
- R6: A write to register 24 while command-in-progress is set is dropped. No `cmd_stb` pulse follows, `cmd_byte` is unchanged, and last-command-ignored is set. A read at location 0 clears last-command-ignored.
- R7: While `eng_busy` is high, a data access to any register other than 24 or 25 reads 0x00, drops its write and leaves the pointer unchanged.
- R8: A pulse on `eng_int` loads `eng_code` into status register 23 and sets interrupt pending. A host read of register 23 clears interrupt pending.
- R9: A pulse on `eng_rdy`, or on `eng_rx_vld` (which also loads `eng_rx_byte` into register 25), sets data buffer ready. Any host access to register 25 clears it. A host write to 25 pulses `dat_wr_stb` in the next cycle with the byte on `tx_byte`. A host read of 25 pulses `dat_rd_stb` in the next cycle.
- R10: Synchronous active-low reset sets the pointer to 0, clears all 26 registers and clears every status flag and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Host access enable |
| a0 | input | 1 | Host location: 0 address/status, 1 data |
| rd | input | 1 | Host read |
| wr | input | 1 | Host write |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte (combinational) |
| eng_busy | input | 1 | Engine busy, restricts register access |
| eng_perr | input | 1 | Engine parity error level |
| eng_done | input | 1 | Command finished, clears command-in-progress |
| eng_int | input | 1 | Interrupt event, loads the status register |
| eng_code | input | 8 | Completion code for the status register |
| eng_rdy | input | 1 | Engine can accept a byte to send |
| eng_rx_vld | input | 1 | Engine deposits a received byte |
| eng_rx_byte | input | 8 | Received byte |
| cmd_stb | output | 1 | One-cycle pulse for an accepted command |
| cmd_byte | output | 8 | Current command register |
| dat_wr_stb | output | 1 | Host wrote the data register |
| dat_rd_stb | output | 1 | Host read the data register |
| tx_byte | output | 8 | Current data register |

## Verification
`rdata` is combinational, so a read is due in the same cycle as the request. The bench samples it one nanosecond after driving the request on a falling edge. Pointer moves, register writes, status flags and the three strobes are all due one cycle after the rising edge that sees the access. Each host or engine task therefore returns on the following falling edge, and strobe checks are made there, before the next rising edge ends the pulse. Flag values are read back at location 0, and register contents through the data port, in later accesses.

// File: rtl/ind_reg_port.sv
module ind_reg_port #(
  parameter int DW    = 8,
  parameter int NREGS = 26,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          a0,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          eng_busy,
  input  logic          eng_perr,
  input  logic          eng_done,
  input  logic          eng_int,
  input  logic [DW-1:0] eng_code,
  input  logic          eng_rdy,
  input  logic          eng_rx_vld,
  input  logic [DW-1:0] eng_rx_byte,
  output logic          cmd_stb,
  output logic [DW-1:0] cmd_byte,
  output logic          dat_wr_stb,
  output logic          dat_rd_stb,
  output logic [DW-1:0] tx_byte
);

  localparam logic [AW-1:0] DAT_P  = AW'(NREGS - 1);
  localparam logic [AW-1:0] CMD_P  = AW'(NREGS - 2);
  localparam logic [AW-1:0] STAT_P = AW'(NREGS - 3);
  localparam logic [DW-1:0] LIM    = DW'(NREGS);

  logic [DW-1:0] regs [NREGS];
  logic [AW-1:0] ptr;
  logic irq, lci, cip, dbr;

  wire ptr_wr   = cs & wr & ~a0;
  wire aux_rd   = cs & rd & ~a0;
  wire dacc     = cs & a0 & (rd | wr);
  wire open_reg = ~eng_busy | (ptr == CMD_P) | (ptr == DAT_P);
  wire hit      = dacc & open_reg;
  wire cmd_wr   = hit & wr & (ptr == CMD_P);
  wire cmd_ok   = cmd_wr & ~cip;
  wire cmd_drop = cmd_wr & cip;
  wire dat_hit  = hit & (ptr == DAT_P);

  wire [DW-1:0] aux = {irq, lci, eng_busy, cip, 2'b00, eng_perr, dbr};

  assign rdata    = !a0 ? aux : (open_reg ? regs[ptr] : '0);
  assign cmd_byte = regs[CMD_P];
  assign tx_byte  = regs[DAT_P];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (hit && wr && ptr != CMD_P) regs[ptr] <= wdata;
      if (cmd_ok)     regs[CMD_P]  <= wdata;
      if (eng_int)    regs[STAT_P] <= eng_code;
      if (eng_rx_vld) regs[DAT_P]  <= eng_rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ptr <= '0;
    else if (ptr_wr && wdata < LIM) ptr <= wdata[AW-1:0];
    else if (hit && ptr < CMD_P)     ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0; lci <= 1'b0; cip <= 1'b0; dbr <= 1'b0;
      cmd_stb <= 1'b0; dat_wr_stb <= 1'b0; dat_rd_stb <= 1'b0;
    end else begin
      if (eng_int) irq <= 1'b1;
      else if (hit && rd && ptr == STAT_P) irq <= 1'b0;
      if (cmd_drop) lci <= 1'b1;
      else if (aux_rd) lci <= 1'b0;
      if (cmd_ok) cip <= 1'b1;
      else if (eng_done) cip <= 1'b0;
      if (eng_rdy || eng_rx_vld) dbr <= 1'b1;
      else if (dat_hit) dbr <= 1'b0;
      cmd_stb    <= cmd_ok;
      dat_wr_stb <= dat_hit & wr;
      dat_rd_stb <= dat_hit & rd;
    end
  end

  assert_cmd_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && a0 && ptr == CMD_P && !cip) |=> (cip && cmd_stb && cmd_byte == $past(wdata)));

  assert_cmd_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && a0 && ptr == CMD_P && cip) |=> (lci && !cmd_stb && $stable(cmd_byte)));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && a0 && ptr >= CMD_P) |=> $stable(ptr));

  assert_busy_no_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && a0 && eng_busy && ptr < CMD_P) |=> $stable(ptr));

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && a0 && !eng_busy && ptr == STAT_P && !eng_int) |=> !irq);

  assert_rx_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_vld |=> (dbr && tx_byte == $past(eng_rx_byte)));

endmodule

// File: tb/ind_reg_port_tb.sv
module ind_reg_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, a0 = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic eng_busy = 0, eng_perr = 0, eng_done = 0, eng_int = 0;
  logic [7:0] eng_code = 0;
  logic eng_rdy = 0, eng_rx_vld = 0;
  logic [7:0] eng_rx_byte = 0;
  logic cmd_stb, dat_wr_stb, dat_rd_stb;
  logic [7:0] cmd_byte, tx_byte;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  ind_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .eng_busy(eng_busy), .eng_perr(eng_perr),
    .eng_done(eng_done), .eng_int(eng_int), .eng_code(eng_code),
    .eng_rdy(eng_rdy), .eng_rx_vld(eng_rx_vld), .eng_rx_byte(eng_rx_byte),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .dat_wr_stb(dat_wr_stb),
    .dat_rd_stb(dat_rd_stb), .tx_byte(tx_byte)
  );

  // op: 0 write loc0, 1 write loc1, 2 read loc0, 3 read loc1 ; {op, data, expect}
  localparam int NV = 34;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h12, 8'h00}, {2'd1, 8'h12, 8'h00}, {2'd1, 8'h34, 8'h00}, {2'd1, 8'h56, 8'h00},
    {2'd0, 8'h12, 8'h00}, {2'd3, 8'h00, 8'h12}, {2'd3, 8'h00, 8'h34}, {2'd3, 8'h00, 8'h56},
    {2'd2, 8'h00, 8'h00}, {2'd0, 8'h03, 8'h00},
    {2'd1, 8'hA1, 8'h00}, {2'd1, 8'hA2, 8'h00}, {2'd1, 8'hA3, 8'h00}, {2'd1, 8'hA4, 8'h00},
    {2'd1, 8'hA5, 8'h00}, {2'd1, 8'hA6, 8'h00}, {2'd1, 8'hA7, 8'h00}, {2'd1, 8'hA8, 8'h00},
    {2'd1, 8'hA9, 8'h00}, {2'd1, 8'hAA, 8'h00}, {2'd1, 8'hAB, 8'h00}, {2'd1, 8'hAC, 8'h00},
    {2'd0, 8'h0E, 8'h00}, {2'd3, 8'h00, 8'hAC}, {2'd3, 8'h00, 8'h00},
    {2'd0, 8'h02, 8'h00}, {2'd1, 8'h77, 8'h00}, {2'd0, 8'h02, 8'h00}, {2'd3, 8'h00, 8'h77},
    {2'd3, 8'h00, 8'hA1}, {2'd0, 8'h1A, 8'h00}, {2'd3, 8'h00, 8'hA2},
    {2'd0, 8'h16, 8'h00}, {2'd1, 8'h5A, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic loc, input logic [7:0] d);
    @(negedge clk); cs = 1; a0 = loc; wr = 1; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic hrd(input logic loc, output logic [7:0] d);
    @(negedge clk); cs = 1; a0 = loc; rd = 1;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #800000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    hrd(0, v); check("R10 aux after reset", v, 8'h00);
    hrd(1, v); check("R10 reg0 after reset", v, 8'h00);
    hwr(0, 8'd5); hrd(1, v); check("R10 reg5 after reset", v, 8'h00);

    // R2 R3 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: hwr(0, VEC[i][15:8]);
        2'd1: hwr(1, VEC[i][15:8]);
        2'd2: begin hrd(0, v); check("R1 vector aux", v, VEC[i][7:0]); end
        default: begin hrd(1, v); check("R3 R4 R2 vector data", v, VEC[i][7:0]); end
      endcase
    end

    // R5 command accept, R6 drop while in progress
    hwr(0, 8'd24); hwr(1, 8'h89);
    check("R5 cmd_stb pulse", {7'd0, cmd_stb}, 8'h01);
    check("R5 cmd_byte", cmd_byte, 8'h89);
    @(negedge clk); check("R5 cmd_stb one cycle", {7'd0, cmd_stb}, 8'h00);
    hrd(0, v); check("R5 cip set", v, 8'h10);
    hwr(1, 8'h07);
    check("R6 no strobe on drop", {7'd0, cmd_stb}, 8'h00);
    check("R6 cmd_byte kept", cmd_byte, 8'h89);
    hrd(0, v); check("R6 lci set", v, 8'h50);
    hrd(0, v); check("R6 lci cleared by aux read", v, 8'h10);
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
    hrd(0, v); check("R5 done clears cip", v, 8'h00);
    hwr(1, 8'h22);
    check("R3 pointer held at 24", cmd_byte, 8'h22);
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;

    // R8 interrupt and status register
    @(negedge clk); eng_int = 1; eng_code = 8'h42; @(negedge clk); eng_int = 0;
    hrd(0, v); check("R8 irq set", v, 8'h80);
    hwr(0, 8'd23); hrd(1, v); check("R8 status code", v, 8'h42);
    hrd(0, v); check("R8 irq cleared", v, 8'h00);

    // R9 data buffer handshake
    @(negedge clk); eng_rx_vld = 1; eng_rx_byte = 8'h3C; @(negedge clk); eng_rx_vld = 0;
    hrd(0, v); check("R9 dbr on rx", v, 8'h01);
    hwr(0, 8'd25); hrd(1, v); check("R9 rx byte", v, 8'h3C);
    check("R9 dat_rd_stb", {7'd0, dat_rd_stb}, 8'h01);
    hrd(0, v); check("R9 dbr cleared", v, 8'h00);
    hrd(1, v); check("R3 pointer held at 25", v, 8'h3C);
    @(negedge clk); eng_rdy = 1; @(negedge clk); eng_rdy = 0;
    hrd(0, v); check("R9 dbr on rdy", v, 8'h01);
    hwr(1, 8'h99);
    check("R9 dat_wr_stb", {7'd0, dat_wr_stb}, 8'h01);
    check("R9 tx_byte", tx_byte, 8'h99);
    hrd(0, v); check("R9 dbr cleared by write", v, 8'h00);

    // R7 busy restriction, R1 live bits
    eng_busy = 1;
    hrd(0, v); check("R1 busy bit", v, 8'h20);
    hwr(0, 8'd18); hrd(1, v); check("R7 hidden read zero", v, 8'h00);
    hwr(1, 8'hFF);
    hwr(0, 8'd25); hrd(1, v); check("R7 data reg open", v, 8'h99);
    hwr(0, 8'd18);
    eng_busy = 0;
    hrd(1, v); check("R7 write dropped no advance", v, 8'h12);
    hrd(1, v); check("R3 advance after busy", v, 8'h34);
    eng_perr = 1;
    hrd(0, v); check("R1 parity bit", v, 8'h02);
    eng_perr = 0;

    // R10 reset mid-run
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    hrd(0, v); check("R10 aux after second reset", v, 8'h00);
    hrd(1, v); check("R10 pointer at reg0", v, 8'h00);
    hwr(0, 8'd18); hrd(1, v); check("R10 count cleared", v, 8'h00);
    check("R10 tx_byte cleared", tx_byte, 8'h00);

    finish_run();
  end
endmodule